// File: doc/BRIEF.md
# Masked Repeating Alarm Comparator

This block is the alarm unit of a real-time clock that counts in BCD. It keeps four alarm bytes: seconds, minutes, hours and day of month. Bit 7 of each byte is a mask bit that removes that field from the comparison. The clock counter outside this block drives the current time as four BCD buses and pulses a one-second strobe. On each strobe the block compares the unmasked alarm fields with the current time. On a match it drives a single-cycle interrupt pulse and sets a sticky alarm flag.

The mask bits together set the repeat rate. With all four clear the alarm repeats monthly (date, hour, minute and second must all match). With only the date masked it repeats daily. With date and hour masked it repeats hourly. With date, hour and minute masked it repeats every minute. With all four masked it fires on every second. Any other mask pattern is illegal and the alarm stays silent.

Software reaches the block through a byte-wide register port that carries a valid/ready request and a valid/ready response. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. Only reads produce a response. The response holds one entry, so `req_ready` drops while a read response is waiting and `rsp_ready` is low. The response stays stable until it is taken. Writes need no response.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all four alarm bytes read 0x00, the alarm flag and `alarm_irq` are low, `rsp_valid` is low and `req_ready` is high.
- R2: Alarm bytes sit at offsets 0x2 (seconds), 0x3 (minutes), 0x4 (hours) and 0x5 (date). Each field's BCD value comes from a fixed set of low bits:
  - seconds and minutes use bits 6:0, range 00–59;
  - hours use bits 5:0, range 00–23;
  - date uses bits 5:0, range 01–31.
  
  An accepted write stores bit 7 and the value bits. For hours and date, bit 6 is stored as 0.
- R3: A write is rejected if its value field has a low digit above 9 or lies outside the field's range. A rejected write leaves the stored byte unchanged.
- R4: With all four mask bits clear, the alarm fires only when date, hour, minute and second all equal the current time.
- R5: With only the date mask set, the alarm fires when hour, minute and second match, whatever the date.
- R6: Three more mask patterns are legal:
  - date and hour masked: the alarm compares minute and second;
  - date, hour and minute masked: it compares second only;
  - all four masked: it fires on every strobe.
- R7: Any other mask pattern never fires, even when all fields match.
- R8: A comparison happens only in a cycle with `sec_tick` high. A hit drives `alarm_irq` high for exactly the one cycle that follows the strobe.
- R9: The alarm flag appears on `alarm_flag` and as bit 7 of the flags register at offset 0x0.
  - A hit sets it, and it stays set.
  - An accepted read of offset 0x0 returns the flag's value before that read, then clears it.
  - If a hit and that read fall in the same cycle, the flag ends up set.
- R10: An accepted read delivers its data on `rsp_rdata` with `rsp_valid` high in the next cycle. While `rsp_ready` is low, the response and its data hold steady and `req_ready` stays low.
- R11: A read of any offset other than 0x0 and 0x2–0x5 returns 0xFF. Writes to offset 0x0 or to an unmapped offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sec_tick | input | 1 | One-second strobe from the clock counter |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 8 | Read response data |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The comparator is driven with every legal mask pattern. Each pattern gets one strobe where only the fields it ignores differ, which must fire, and one where a field it compares differs, which must stay quiet. Together these pairs show that each rate looks at exactly its own set of fields.

Illegal mask patterns are driven with fully matching time, and strobe-free cycles are driven with matching time. These show that mask decoding and strobe gating each suppress firing on their own.

A strobe is made to coincide with a flag read to confirm that the hit wins over the clear. Writes with a bad low digit, values at each range edge and values just past each edge separate accepted writes from rejected ones.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int REG_AW     = 4;
  localparam int N_FIELDS   = 4;
  localparam int FIELD_BASE = 2;
  localparam int FLAG_BIT   = 7;
  localparam logic [REG_AW-1:0] OFS_FLAGS = REG_AW'(0);
  localparam logic [7:0] UNMAPPED_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    RATE_MONTH, RATE_DAY, RATE_HOUR, RATE_MIN, RATE_SEC, RATE_OFF
  } rate_e;

  // field index: 0 seconds, 1 minutes, 2 hours, 3 date
  function automatic logic [6:0] fld_bits(int idx);
    return (idx < 2) ? 7'h7F : 7'h3F;
  endfunction

  function automatic logic [6:0] fld_lo(int idx);
    return (idx == 3) ? 7'h01 : 7'h00;
  endfunction

  function automatic logic [6:0] fld_hi(int idx);
    case (idx)
      2:       return 7'h23;
      3:       return 7'h31;
      default: return 7'h59;
    endcase
  endfunction

  function automatic logic bcd_ok(logic [6:0] v, logic [6:0] lo, logic [6:0] hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/rtc_alm_regs.sv
module rtc_alm_regs
  import rtc_alm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [REG_AW-1:0]      req_addr,
  input  logic [7:0]             req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [7:0]             rsp_rdata,
  input  logic                   flag_i,
  output logic                   flag_clr_o,
  output logic [N_FIELDS*8-1:0]  fields_o
);
  logic [7:0] field_q [N_FIELDS];
  logic       wr_fire, rd_fire;
  logic [7:0] rd_mux;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign wr_fire    = req_valid && req_ready && req_write;
  assign rd_fire    = req_valid && req_ready && !req_write;
  assign flag_clr_o = rd_fire && (req_addr == OFS_FLAGS);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    localparam logic [REG_AW-1:0] MY_OFS = REG_AW'(FIELD_BASE + i);
    logic [6:0] val;
    logic       hit_ok;
    assign val    = req_wdata[6:0] & fld_bits(i);
    assign hit_ok = wr_fire && (req_addr == MY_OFS) && bcd_ok(val, fld_lo(i), fld_hi(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      field_q[i] <= 8'h00;
      else if (hit_ok) field_q[i] <= {req_wdata[7], val};
    end
    assign fields_o[i*8 +: 8] = field_q[i];

    AST_BAD_DIGIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && req_addr == MY_OFS && req_wdata[3:0] > 4'd9) |=> $stable(field_q[i])); // R3
  end

  always_comb begin
    rd_mux = UNMAPPED_BYTE;
    if (req_addr == OFS_FLAGS) rd_mux = 8'(flag_i) << FLAG_BIT;
    for (int k = 0; k < N_FIELDS; k++)
      if (req_addr == REG_AW'(FIELD_BASE + k)) rd_mux = field_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
endmodule

// File: rtl/rtc_alm_match.sv
module rtc_alm_match
  import rtc_alm_pkg::*;
(
  input  logic [N_FIELDS*8-1:0] fields_i,
  input  logic [6:0]            now_sec,
  input  logic [6:0]            now_min,
  input  logic [5:0]            now_hour,
  input  logic [5:0]            now_date,
  output rate_e                 rate_o,
  output logic                  match_o
);
  logic [7:0] a_sec, a_min, a_hour, a_date;
  logic       eq_sec, eq_min, eq_hour, eq_date;

  assign a_sec  = fields_i[7:0];
  assign a_min  = fields_i[15:8];
  assign a_hour = fields_i[23:16];
  assign a_date = fields_i[31:24];

  assign eq_sec  = a_sec[6:0]  == now_sec;
  assign eq_min  = a_min[6:0]  == now_min;
  assign eq_hour = a_hour[6:0] == {1'b0, now_hour};
  assign eq_date = a_date[6:0] == {1'b0, now_date};

  always_comb begin
    case ({a_date[7], a_hour[7], a_min[7], a_sec[7]})
      4'b0000: rate_o = RATE_MONTH;
      4'b1000: rate_o = RATE_DAY;
      4'b1100: rate_o = RATE_HOUR;
      4'b1110: rate_o = RATE_MIN;
      4'b1111: rate_o = RATE_SEC;
      default: rate_o = RATE_OFF;
    endcase
  end

  always_comb begin
    case (rate_o)
      RATE_MONTH: match_o = eq_date && eq_hour && eq_min && eq_sec;
      RATE_DAY:   match_o = eq_hour && eq_min && eq_sec;
      RATE_HOUR:  match_o = eq_min && eq_sec;
      RATE_MIN:   match_o = eq_sec;
      RATE_SEC:   match_o = 1'b1;
      default:    match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_alm_irq.sv
module rtc_alm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  input  logic clr_i,
  output logic irq_o,
  output logic flag_o
);
  logic hit;
  assign hit = tick_i && match_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      irq_o <= hit;
      if (hit)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i)); // R8
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o); // R9
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic [5:0]        now_date,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  output logic              alarm_irq,
  output logic              alarm_flag
);
  logic [N_FIELDS*8-1:0] fields;
  logic                  flag_clr, match;
  rate_e                 rate;
  logic [3:0]            mask_bits;
  logic                  mask_legal;

  rtc_alm_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .flag_i(alarm_flag), .flag_clr_o(flag_clr), .fields_o(fields)
  );

  rtc_alm_match u_match (
    .fields_i(fields), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_date(now_date),
    .rate_o(rate), .match_o(match)
  );

  rtc_alm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tick_i(sec_tick), .match_i(match),
    .clr_i(flag_clr), .irq_o(alarm_irq), .flag_o(alarm_flag)
  );

  assign mask_bits  = {fields[31], fields[23], fields[15], fields[7]};
  assign mask_legal = (mask_bits == 4'b0000) || (mask_bits == 4'b1000) ||
                      (mask_bits == 4'b1100) || (mask_bits == 4'b1110) ||
                      (mask_bits == 4'b1111);

  AST_ILLEGAL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !mask_legal) |=> !alarm_irq); // R7
  AST_NO_TICK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !alarm_irq); // R8
  AST_RATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && rate == RATE_OFF) |=> !alarm_irq); // R7
endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0;
  logic [5:0] now_hour = '0, now_date = '0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, alarm_irq, alarm_flag;
  logic [7:0] rsp_rdata;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_alarm_match u_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .alarm_irq(alarm_irq), .alarm_flag(alarm_flag)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic tick_chk(string tag, logic [6:0] s, logic [6:0] m,
                          logic [5:0] h, logic [5:0] dt, logic exp);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = dt; sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
    chk({tag, " irq"}, 8'(alarm_irq), 8'(exp));
    @(negedge clk);
    chk({tag, " irq ends"}, 8'(alarm_irq), 8'h00);
    rd_chk({tag, " flag read"}, 4'h0, exp ? 8'h80 : 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 8'(req_ready), 8'h01);
    chk("R1 rsp_valid", 8'(rsp_valid), 8'h00);
    chk("R1 irq", 8'(alarm_irq), 8'h00);
    chk("R1 flag", 8'(alarm_flag), 8'h00);
    for (int i = 2; i < 6; i++) rd_chk("R1 alarm byte", 4'(i), 8'h00);
  endtask

  task automatic t_ranges;
    wr(4'h2, 8'h59); rd_chk("R2 sec 59", 4'h2, 8'h59);
    wr(4'h2, 8'h60); rd_chk("R3 sec 60 rejected", 4'h2, 8'h59);
    wr(4'h2, 8'h5A); rd_chk("R3 sec digit A rejected", 4'h2, 8'h59);
    wr(4'h2, 8'hD9); rd_chk("R2 sec masked 59", 4'h2, 8'hD9);
    wr(4'h3, 8'h00); rd_chk("R2 min 00", 4'h3, 8'h00);
    wr(4'h3, 8'h7F); rd_chk("R3 min 7F rejected", 4'h3, 8'h00);
    wr(4'h4, 8'h23); rd_chk("R2 hour 23", 4'h4, 8'h23);
    wr(4'h4, 8'h24); rd_chk("R3 hour 24 rejected", 4'h4, 8'h23);
    wr(4'h4, 8'h1A); rd_chk("R3 hour digit A rejected", 4'h4, 8'h23);
    wr(4'h4, 8'h52); rd_chk("R2 hour bit6 dropped", 4'h4, 8'h12);
    wr(4'h5, 8'h31); rd_chk("R2 date 31", 4'h5, 8'h31);
    wr(4'h5, 8'h00); rd_chk("R3 date 00 rejected", 4'h5, 8'h31);
    wr(4'h5, 8'h32); rd_chk("R3 date 32 rejected", 4'h5, 8'h31);
    wr(4'h5, 8'hF1); rd_chk("R2 date bit6 dropped", 4'h5, 8'hB1);
  endtask

  task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
    wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, d);
  endtask

  task automatic t_rates;
    set_alarm(8'h45, 8'h30, 8'h10, 8'h15);
    tick_chk("R4 monthly match", 7'h45, 7'h30, 6'h10, 6'h15, 1);
    tick_chk("R4 monthly date differs", 7'h45, 7'h30, 6'h10, 6'h16, 0);
    set_alarm(8'h45, 8'h30, 8'h10, 8'h95);
    tick_chk("R5 daily other date", 7'h45, 7'h30, 6'h10, 6'h22, 1);
    tick_chk("R5 daily hour differs", 7'h45, 7'h30, 6'h11, 6'h22, 0);
    set_alarm(8'h45, 8'h30, 8'h90, 8'h95);
    tick_chk("R6 hourly other hour", 7'h45, 7'h30, 6'h03, 6'h07, 1);
    tick_chk("R6 hourly minute differs", 7'h45, 7'h31, 6'h03, 6'h07, 0);
    set_alarm(8'h45, 8'hB0, 8'h90, 8'h95);
    tick_chk("R6 minute other minute", 7'h45, 7'h12, 6'h03, 6'h07, 1);
    tick_chk("R6 minute second differs", 7'h46, 7'h12, 6'h03, 6'h07, 0);
    set_alarm(8'hC5, 8'hB0, 8'h90, 8'h95);
    tick_chk("R6 every second", 7'h00, 7'h00, 6'h00, 6'h01, 1);
  endtask

  task automatic t_illegal;
    set_alarm(8'hC5, 8'hB0, 8'h90, 8'h15);
    tick_chk("R7 date unmasked rest masked", 7'h45, 7'h30, 6'h10, 6'h15, 0);
    set_alarm(8'hC5, 8'h30, 8'h10, 8'h15);
    tick_chk("R7 only seconds masked", 7'h45, 7'h30, 6'h10, 6'h15, 0);
  endtask

  task automatic t_no_tick;
    set_alarm(8'h45, 8'h30, 8'h10, 8'h15);
    @(negedge clk);
    now_sec = 7'h45; now_min = 7'h30; now_hour = 6'h10; now_date = 6'h15;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 no strobe no irq", 8'(alarm_irq), 8'h00);
    end
    chk("R8 no strobe no flag", 8'(alarm_flag), 8'h00);
  endtask

  task automatic t_flag_race;
    // monthly alarm still set and matching from previous task
    @(negedge clk);
    sec_tick = 1; req_valid = 1; req_write = 0; req_addr = 4'h0;
    @(negedge clk);
    sec_tick = 0; req_valid = 0;
    chk("R9 race read sees old flag", rsp_rdata, 8'h00);
    chk("R8 race irq", 8'(alarm_irq), 8'h01);
    chk("R9 set wins", 8'(alarm_flag), 8'h01);
    rd_chk("R9 flag still set", 4'h0, 8'h80);
    rd_chk("R9 flag cleared by read", 4'h0, 8'h00);
    chk("R9 flag pin cleared", 8'(alarm_flag), 8'h00);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 4'h0;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R10 rsp held valid", 8'(rsp_valid), 8'h01);
      chk("R10 rsp held data", rsp_rdata, 8'h80);
      chk("R10 ready low", 8'(req_ready), 8'h00);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R10 rsp drained", 8'(rsp_valid), 8'h00);
    chk("R10 ready back", 8'(req_ready), 8'h01);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 unmapped read", 4'h9, 8'hFF);
    rd_chk("R11 unmapped read 1", 4'h1, 8'hFF);
    wr(4'h9, 8'h00);
    rd_chk("R11 unmapped write no effect", 4'h2, 8'h45);
    wr(4'h0, 8'h80);
    rd_chk("R11 flags write ignored", 4'h0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ranges();
    t_rates();
    t_illegal();
    t_no_tick();
    t_flag_race();
    t_backpressure();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule